// File: doc/BRIEF.md
# Supply Voltage Detector with Delayed Reset Release

This block turns a stream of digitised input-supply readings into two control outputs. The first is an undervoltage-lockout flag with fixed hysteresis. The second is an active-low system reset. Readings arrive as a code from an external converter, each marked by a one-cycle valid strobe. A one-cycle millisecond tick paces the release delay. Two configuration fields set the behaviour: one picks the detect threshold and one picks the release delay. The converter scaling is set by a parameter, millivolts per LSB (default 4 mV).

A small state machine carries the supply condition. Its states are:
- `ST_OFF`: lockout active, reset asserted.
- `ST_LOW`: lockout released, but the supply is under the detect threshold, so reset stays asserted.
- `ST_WAIT`: the supply is qualified and the delay timer is counting. Reset stays asserted.
- `ST_RUN`: reset is released.

The transitions are:
- `OFF→WAIT` or `OFF→LOW`: a reading above the release threshold. The target depends on whether the reading also reaches the detect threshold.
- `LOW→WAIT`: a reading at or above the detect threshold.
- `WAIT→RUN`: the timer reports that the delay has elapsed.
- `WAIT/RUN→LOW`: a dip under the detect threshold.
- `LOW/WAIT/RUN→OFF`: a reading under the lockout threshold.

The reset is not latched. It follows the supply, and every disqualification restarts the delay from zero.

Top module: `supply_reset_gen`

## Requirements
- R1: After reset, and until the first valid reading, `uvlo_ok_o` is 0 and `sys_rst_n_o` is 0.
- R2: While locked out, a valid reading strictly greater than 2300/MV_PER_LSB releases the lockout. The default release code is 575, and a code of exactly 575 does not release it. `uvlo_ok_o` goes to 1 on the clock edge after the reading.
- R3: While released, a valid reading strictly below 1900/MV_PER_LSB re-enters lockout. The default code is 475. `uvlo_ok_o` and `sys_rst_n_o` both go to 0, and readings between 475 and 575 do not release the lockout again.
- R4: The detect threshold code is (2000 + 100·`det_lvl_i`)/MV_PER_LSB, with `det_lvl_i` a 3-bit field. The default gives codes 500 to 675. A valid reading below this code forces `sys_rst_n_o` to 0 on the next edge, and reset is not latched.
- R5: The release delay is `dly_sel_i`·TICKS_PER_STEP millisecond ticks, with `dly_sel_i` a 4-bit field and TICKS_PER_STEP 5 by default. The delay is counted from the qualifying reading. `sys_rst_n_o` rises one clock after the tick that completes the count. With a delay of 0, it rises two edges after the qualifying reading.
- R6: A dip under the detect threshold, or a return to lockout, clears the delay count. A later qualifying reading then needs the full delay again.
- R7: The reading code has no effect on either output while `smp_vld_i` is 0.
- R8: A reading between the lockout-fall code and the detect code keeps `uvlo_ok_o` at 1 while `sys_rst_n_o` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| arst_n | input | 1 | Asynchronous active-low block reset |
| smp_vld_i | input | 1 | Reading valid strobe |
| vin_code_i | input | CODE_W | Digitised supply reading |
| ms_tick_i | input | 1 | One-cycle millisecond tick |
| det_lvl_i | input | LVL_W | Detect threshold select |
| dly_sel_i | input | DLY_W | Release delay select |
| uvlo_ok_o | output | 1 | Lockout released flag |
| sys_rst_n_o | output | 1 | Active-low system reset |

## Verification
The bench probes the lockout thresholds at their exact codes. A comparison written with the wrong strictness would release at 575 or drop at 475. It also probes the hysteresis gap, where a design without hysteresis would release again at 476. The delay is checked one tick short of its target and at the target. A counter off by one would open the reset early or late. Dips in the middle of a count, with readings resumed afterwards, show whether a design keeps a stale count and releases too soon. A zero delay and a detect level above the release point cover the cases where a design skips the wait state or ties reset to the lockout flag.

// File: rtl/srg_pkg.sv
package srg_pkg;
    typedef enum logic [1:0] {
        ST_OFF  = 2'd0,
        ST_LOW  = 2'd1,
        ST_WAIT = 2'd2,
        ST_RUN  = 2'd3
    } srg_state_e;
endpackage

// File: rtl/srg_thresholds.sv
module srg_thresholds #(
    parameter int CODE_W      = 10,
    parameter int LVL_W       = 3,
    parameter int MV_PER_LSB  = 4,
    parameter int RISE_MV     = 2300,
    parameter int FALL_MV     = 1900,
    parameter int DET_BASE_MV = 2000,
    parameter int DET_STEP_MV = 100
) (
    input  logic [LVL_W-1:0]  lvl,
    output logic [CODE_W-1:0] rise_code,
    output logic [CODE_W-1:0] fall_code,
    output logic [CODE_W-1:0] det_code
);
    localparam int NLVL   = 2 ** LVL_W;
    localparam int RISE_C = RISE_MV / MV_PER_LSB;
    localparam int FALL_C = FALL_MV / MV_PER_LSB;

    logic [CODE_W-1:0] det_tab [NLVL];

    for (genvar g = 0; g < NLVL; g++) begin : g_det
        localparam int DET_C = (DET_BASE_MV + DET_STEP_MV * g) / MV_PER_LSB;
        assign det_tab[g] = CODE_W'(DET_C);
    end

    assign rise_code = CODE_W'(RISE_C);
    assign fall_code = CODE_W'(FALL_C);
    assign det_code  = det_tab[lvl];
endmodule

// File: rtl/srg_delay_timer.sv
module srg_delay_timer #(
    parameter int DLY_W          = 4,
    parameter int TICKS_PER_STEP = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             tick,
    input  logic [DLY_W-1:0] dly,
    output logic             done
);
    localparam int MAX_TGT = (2 ** DLY_W - 1) * TICKS_PER_STEP;
    localparam int CNT_W   = $clog2(MAX_TGT + 1) + 1;

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] target;

    assign target = CNT_W'(dly) * CNT_W'(TICKS_PER_STEP);
    assign done   = en && (cnt >= target);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                       cnt <= '0;
        else if (!en)                     cnt <= '0;
        else if (tick && (cnt < target))  cnt <= cnt + 1'b1;
    end

    // Counter holds between ticks while enabled (R5)
    assert_cnt_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !tick) |=> $stable(cnt) || !en);
endmodule

// File: rtl/srg_fsm.sv
module srg_fsm
    import srg_pkg::*;
#(
    parameter int CODE_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              smp_vld,
    input  logic [CODE_W-1:0] code,
    input  logic [CODE_W-1:0] rise_code,
    input  logic [CODE_W-1:0] fall_code,
    input  logic [CODE_W-1:0] det_code,
    input  logic              timer_done,
    output logic              timer_en,
    output logic              uvlo_ok,
    output logic              rst_out_n
);
    srg_state_e state, nxt;

    logic below_fall, below_det, above_rise;
    assign below_fall = code < fall_code;
    assign below_det  = code < det_code;
    assign above_rise = code > rise_code;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_OFF;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_OFF: begin
                if (smp_vld && above_rise) nxt = below_det ? ST_LOW : ST_WAIT;
            end
            ST_LOW: begin
                if (smp_vld) begin
                    if (below_fall)      nxt = ST_OFF;
                    else if (!below_det) nxt = ST_WAIT;
                end
            end
            ST_WAIT: begin
                if (smp_vld && below_fall)     nxt = ST_OFF;
                else if (smp_vld && below_det) nxt = ST_LOW;
                else if (timer_done)           nxt = ST_RUN;
            end
            ST_RUN: begin
                if (smp_vld && below_fall)     nxt = ST_OFF;
                else if (smp_vld && below_det) nxt = ST_LOW;
            end
            default: nxt = ST_OFF;
        endcase
    end

    always_comb begin
        timer_en  = (state == ST_WAIT);
        uvlo_ok   = (state != ST_OFF);
        rst_out_n = (state == ST_RUN);
    end

    // A reading under the detect level asserts reset next cycle (R4)
    assert_dip_resets_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_vld && below_det) |=> !rst_out_n);
    // A reading under the fall code enters lockout (R3)
    assert_fall_locks_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_vld && below_fall) |=> !uvlo_ok);
    // A reading above the rise code releases lockout (R2)
    assert_rise_releases_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!uvlo_ok && smp_vld && above_rise) |=> uvlo_ok);
    // Reset only releases once the delay timer has finished (R5)
    assert_release_after_delay_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_out_n) |-> $past(timer_done));
    // Without a valid reading, lockout is held (R7)
    assert_off_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!smp_vld && !uvlo_ok) |=> !uvlo_ok);
endmodule

// File: rtl/supply_reset_gen.sv
module supply_reset_gen #(
    parameter int CODE_W         = 10,
    parameter int LVL_W          = 3,
    parameter int DLY_W          = 4,
    parameter int MV_PER_LSB     = 4,
    parameter int TICKS_PER_STEP = 5
) (
    input  logic              clk,
    input  logic              arst_n,
    input  logic              smp_vld_i,
    input  logic [CODE_W-1:0] vin_code_i,
    input  logic              ms_tick_i,
    input  logic [LVL_W-1:0]  det_lvl_i,
    input  logic [DLY_W-1:0]  dly_sel_i,
    output logic              uvlo_ok_o,
    output logic              sys_rst_n_o
);
    logic [CODE_W-1:0] rise_code, fall_code, det_code;
    logic              timer_en, timer_done;

    srg_thresholds #(
        .CODE_W(CODE_W), .LVL_W(LVL_W), .MV_PER_LSB(MV_PER_LSB),
        .RISE_MV(2300), .FALL_MV(1900), .DET_BASE_MV(2000), .DET_STEP_MV(100)
    ) u_thr (
        .lvl(det_lvl_i), .rise_code(rise_code), .fall_code(fall_code), .det_code(det_code)
    );

    srg_delay_timer #(.DLY_W(DLY_W), .TICKS_PER_STEP(TICKS_PER_STEP)) u_tmr (
        .clk(clk), .rst_n(arst_n), .en(timer_en), .tick(ms_tick_i),
        .dly(dly_sel_i), .done(timer_done)
    );

    srg_fsm #(.CODE_W(CODE_W)) u_fsm (
        .clk(clk), .rst_n(arst_n), .smp_vld(smp_vld_i), .code(vin_code_i),
        .rise_code(rise_code), .fall_code(fall_code), .det_code(det_code),
        .timer_done(timer_done), .timer_en(timer_en),
        .uvlo_ok(uvlo_ok_o), .rst_out_n(sys_rst_n_o)
    );
endmodule

// File: tb/supply_reset_gen_test.sv
module supply_reset_gen_test;
    localparam int CLK_PERIOD = 10;
    localparam int CODE_W = 10;
    localparam int MV = 4;
    localparam int TPS = 5;

    logic clk = 1'b0;
    logic arst_n = 1'b0;
    logic smp_vld = 1'b0;
    logic [CODE_W-1:0] code = '0;
    logic tick = 1'b0;
    logic [2:0] lvl = '0;
    logic [3:0] dly = '0;
    logic uvlo_ok, rst_n_out;

    int tests = 0, fails = 0;
    bit finished = 0;

    int m_on = 0, m_q = 0, m_cnt = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    supply_reset_gen #(.CODE_W(CODE_W), .MV_PER_LSB(MV), .TICKS_PER_STEP(TPS)) uut (
        .clk(clk), .arst_n(arst_n), .smp_vld_i(smp_vld), .vin_code_i(code),
        .ms_tick_i(tick), .det_lvl_i(lvl), .dly_sel_i(dly),
        .uvlo_ok_o(uvlo_ok), .sys_rst_n_o(rst_n_out)
    );

    function automatic int rise_c(); return 2300 / MV; endfunction
    function automatic int fall_c(); return 1900 / MV; endfunction
    function automatic int det_c(int l); return (2000 + 100 * l) / MV; endfunction
    function automatic int tgt(); return int'(dly) * TPS; endfunction
    function automatic int exp_rst(); return (m_on && m_q && m_cnt >= tgt()) ? 1 : 0; endfunction

    task automatic check(string tag);
        tests++;
        if (uvlo_ok !== 1'(m_on)) begin
            fails++;
            $display("FAIL %s uvlo_ok actual=%0b expected=%0d", tag, uvlo_ok, m_on);
        end
        tests++;
        if (rst_n_out !== 1'(exp_rst())) begin
            fails++;
            $display("FAIL %s sys_rst_n actual=%0b expected=%0d", tag, rst_n_out, exp_rst());
        end
    endtask

    task automatic do_sample(int c, string tag);
        smp_vld = 1'b1; code = CODE_W'(c);
        @(posedge clk); @(negedge clk);
        smp_vld = 1'b0;
        if (!m_on) begin
            if (c > rise_c()) m_on = 1;
        end else if (c < fall_c()) m_on = 0;
        if (m_on && c >= det_c(int'(lvl))) begin
            if (!m_q) begin m_q = 1; m_cnt = 0; end
        end else begin m_q = 0; m_cnt = 0; end
        @(posedge clk); @(negedge clk);
        check(tag);
    endtask

    task automatic do_ticks(int k, string tag);
        for (int i = 0; i < k; i++) begin
            tick = 1'b1;
            @(posedge clk); @(negedge clk);
            tick = 1'b0;
            if (m_q && m_cnt < tgt()) m_cnt++;
        end
        @(posedge clk); @(negedge clk);
        check(tag);
    endtask

    task automatic do_noise(int c, string tag);
        code = CODE_W'(c);
        @(posedge clk); @(negedge clk);
        @(posedge clk); @(negedge clk);
        check(tag);
    endtask

    task automatic set_cfg(int l, int d);
        if (m_q && m_cnt >= tgt()) m_cnt = 1000;
        lvl = 3'(l); dly = 4'(d);
        @(posedge clk); @(negedge clk);
        if (m_q && m_cnt < 1000 && m_cnt > tgt()) m_cnt = tgt();
        check("cfg R5");
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!finished) begin
            fails++; tests++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        lvl = 3'd0; dly = 4'd2;
        repeat (3) @(negedge clk);
        arst_n = 1'b1;
        @(negedge clk);
        check("R1 power-on");
        do_noise(700, "R1 R7 no valid");
        do_sample(575, "R2 equal to rise code");
        do_sample(576, "R2 release");
        do_ticks(9, "R5 one tick short");
        do_ticks(1, "R5 delay reached");
        do_noise(300, "R7 code ignored");
        do_sample(490, "R4 R8 under detect");
        do_sample(520, "R6 requalify");
        do_ticks(5, "R6 partial count");
        do_sample(480, "R6 dip mid count");
        do_sample(520, "R6 requalify again");
        do_ticks(9, "R6 full delay needed");
        do_ticks(1, "R6 delay reached");
        do_sample(474, "R3 lockout");
        do_sample(476, "R3 hysteresis gap");
        do_sample(575, "R3 still locked");
        set_cfg(0, 0);
        do_sample(600, "R5 zero delay");
        set_cfg(7, 1);
        do_sample(650, "R4 level seven");
        do_sample(675, "R4 level seven reached");
        do_ticks(5, "R5 delay one step");
        for (int it = 0; it < 400; it++) begin
            int op;
            op = int'($urandom % 10);
            if (op < 5)      do_sample(440 + int'($urandom % 260), "R4 random sample");
            else if (op < 8) do_ticks(1 + int'($urandom % 20), "R5 random ticks");
            else if (op < 9) do_noise(int'($urandom % 1024), "R7 random noise");
            else             set_cfg(int'($urandom % 8), int'($urandom % 4));
        end
        finished = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule